// File: doc/BRIEF.md
# Configuration Bitstream Loader

This controller accepts a configuration image as 32-bit words written over a simple memory-mapped bus. The words come either from a processor that polls the FIFO level, or from an external DMA engine that reacts to a request line. The words are held in an on-chip FIFO and then serialised into bytes toward a downstream configurable device, most significant byte first. Serialisation stops once a software-programmed total byte count has been delivered.

The controller combines the current byte count, a downstream done input and any captured error into a status word. It raises an interrupt when loading completes or fails. That interrupt is held until software writes the control register with the enable bit cleared. Writing enable together with the reset bit drives a reset to the downstream device, and this lasts until the control register is rewritten.

Reads are combinational from the address. Writes take effect at the next clock edge. Every register is one 32-bit word.

Top module: `bitstream_loader`

## Requirements
- R1: After reset, the control, status, total, current and FIFO-used registers read 0, the FIFO-size register reads DEPTH*4 (64 by default), and irq, dma_req, cfg_valid and cfg_reset are low.
- R2: The control register at byte offset 0x40 holds the enable bit (bit 0), the device-reset bit (bit 1) and the DMA-mode bit (bit 2), and it reads back the written value in bits 2:0.
- R3: A write anywhere in the data window (address bits 13:12 equal to 2'b11, e.g. 0x3000) is accepted only while enabled. A write while the FIFO is full is dropped and sets the sticky overflow flag in status bit 1. While enable is 0, the FIFO and the serialiser hold no data.
- R4: Each accepted word leaves as four bytes on cfg_data, in the order bits 31:24, 23:16, 15:8, 7:0. One byte moves per cycle in which cfg_valid and cfg_ready are both high. No new word is started once the current count has reached the total.
- R5: The current count at 0x54 rises by 4 for each word whose last byte is delivered. A control write that sets enable while the controller is disabled clears the current count, the accepted count and both error flags.
- R6: The total byte count at 0x50 is written only while enable is 0; a write while enabled is ignored. Bits 1:0 are stored as zero.
- R7: The FIFO-used register at 0x4C reads 4 times the number of words held in the FIFO plus the word in the serialiser, so it reads 0 only when fully drained. The FIFO-size register at 0x48 reads DEPTH*4.
- R8: Status at 0x44 has bit 18 (done) set when the total is nonzero, the current count equals the total and cfg_done_in is high. Bits 15:1 are the error field: bit 1 is overflow, and bit 2 is a sticky downstream error, set when cfg_err_in is high while enabled.
- R9: irq rises while enabled when done is set or the error field is nonzero. It stays high until a control write with bit 0 clear.
- R10: dma_req is high when enable and DMA mode are set, the FIFO has at least DEPTH/2 free words, and fewer bytes than the total have been accepted since enable.
- R11: cfg_reset is high exactly while the control register holds both enable and the device-reset bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register or data window |
| bus_addr | input | 14 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| dma_req | output | 1 | Burst request to an external DMA engine |
| irq | output | 1 | Completion or error interrupt |
| cfg_data | output | 8 | Byte toward the configurable device |
| cfg_valid | output | 1 | cfg_data holds a byte |
| cfg_ready | input | 1 | Device accepts the byte this cycle |
| cfg_done_in | input | 1 | Device reports configuration complete |
| cfg_err_in | input | 1 | Device reports a configuration error |
| cfg_reset | output | 1 | Reset toward the device |

## Verification
A corrupt current count shows within one word time as a wrong value at 0x54, a done flag that never rises, or bytes that continue past the total on cfg_data. A FIFO pointer fault reorders or repeats bytes in the captured stream, or leaves FIFO-used nonzero after draining, visible within a few cycles of the next write. Mis-kept error or interrupt state shows at once in status bits 2:1 and on irq, both before and after the control write that should clear it. A wrong free-space or accepted-byte count shows as dma_req flipping one word early or late.

// File: rtl/bsl_pkg.sv
// Shared constants for the bitstream loader: address map and bit positions.
// Assumes a 14-bit byte address and 32-bit registers.
package bsl_pkg;
    localparam int ADDR_W = 14;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] A_CTRL  = 14'h0040;
    localparam logic [ADDR_W-1:0] A_STAT  = 14'h0044;
    localparam logic [ADDR_W-1:0] A_FSIZE = 14'h0048;
    localparam logic [ADDR_W-1:0] A_FUSED = 14'h004C;
    localparam logic [ADDR_W-1:0] A_TOTAL = 14'h0050;
    localparam logic [ADDR_W-1:0] A_CUR   = 14'h0054;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_RST = 1;
    localparam int CTRL_DMA = 2;

    localparam int ST_OVF  = 1;
    localparam int ST_DERR = 2;
    localparam int ST_DONE = 18;
endpackage

// File: rtl/bsl_fifo.sv
// Word FIFO between bus writes and the byte serialiser.
// Assumes DEPTH is a power of two; the caller never pushes when full.
// flush empties it synchronously.
module bsl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int FCW  = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           flush,
    input  logic           push,
    input  logic [W-1:0]   wdata,
    input  logic           pop,
    output logic [W-1:0]   rdata,
    output logic           full,
    output logic           empty,
    output logic [FCW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;

    assign full  = (count == FCW'(DEPTH));
    assign empty = (count == '0);
    assign rdata = mem[rp];

    // Storage array: written on push, never reset.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R3: occupancy never exceeds the depth.
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FCW'(DEPTH));
endmodule

// File: rtl/bsl_serializer.sv
// Takes one word at a time from the FIFO and emits it as bytes, MSB first,
// over a valid/ready handshake. A word is started only when allow is high.
// Dropping enable discards the word in flight.
module bsl_serializer #(
    parameter int W      = 32,
    parameter int BYTE_W = 8,
    localparam int NB    = W / BYTE_W,
    localparam int IW    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              allow,
    input  logic              src_empty,
    input  logic [W-1:0]      src_data,
    output logic              src_pop,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              word_done,
    output logic              busy
);
    logic [W-1:0]  word_q;
    logic [IW-1:0] idx_q;
    logic [W-1:0]  shifted;

    assign src_pop   = enable && !busy && !src_empty && allow;
    assign out_valid = busy;
    assign word_done = busy && out_ready && (idx_q == IW'(NB - 1));

    // Byte selection: current byte moved to the top of the word.
    always_comb begin
        shifted  = word_q << (idx_q * BYTE_W);
        out_data = shifted[W-1 -: BYTE_W];
    end

    // Word load and byte index advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx_q  <= '0;
            word_q <= '0;
        end else if (!enable) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (src_pop) begin
            word_q <= src_data;
            busy   <= 1'b1;
            idx_q  <= '0;
        end else if (busy && out_ready) begin
            if (idx_q == IW'(NB - 1)) begin
                busy  <= 1'b0;
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R4: an offered byte stays put until it is taken or enable drops.
    a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && enable) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/bsl_regs.sv
// Register file: control, total and current counts, sticky errors, done,
// interrupt, DMA request and data-window decode.
// Assumes the total is a multiple of 4 (low bits are forced to zero).
module bsl_regs
    import bsl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int FCW  = $clog2(DEPTH + 1),
    localparam int CW   = $clog2(DEPTH + 2),
    localparam int BURST = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              fifo_full,
    input  logic [FCW-1:0]    fifo_count,
    input  logic [CW-1:0]     used_words,
    input  logic              word_done,
    input  logic              cfg_done_in,
    input  logic              cfg_err_in,
    output logic              data_push,
    output logic              ctrl_en,
    output logic              allow,
    output logic              dma_req,
    output logic              irq,
    output logic              cfg_reset
);
    localparam logic [DATA_W-1:0] SIZE_BYTES = DATA_W'(DEPTH * 4);
    localparam logic [DATA_W-1:0] STEP       = DATA_W'(4);

    logic [2:0]        ctrl_q;
    logic [DATA_W-1:0] total_q, cur_q, acc_q;
    logic              ovf_q, derr_q, irq_q;
    logic              wr_ctrl, wr_total, wr_data, en_rise, data_drop, done;
    logic [DATA_W-1:0] stat;

    assign ctrl_en   = ctrl_q[CTRL_EN];
    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_total  = bus_wr && (bus_addr == A_TOTAL);
    assign wr_data   = bus_wr && (bus_addr[ADDR_W-1 -: 2] == 2'b11);
    assign en_rise   = wr_ctrl && bus_wdata[CTRL_EN] && !ctrl_en;
    assign data_push = wr_data && ctrl_en && !fifo_full;
    assign data_drop = wr_data && ctrl_en && fifo_full;
    assign done      = (total_q != '0) && (cur_q == total_q) && cfg_done_in;
    assign allow     = cur_q < total_q;
    assign irq       = irq_q;
    assign cfg_reset = ctrl_q[CTRL_EN] && ctrl_q[CTRL_RST];
    assign dma_req   = ctrl_en && ctrl_q[CTRL_DMA] && (acc_q < total_q)
                       && ((DEPTH - int'(fifo_count)) >= BURST);

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[2:0];
    end

    // Total byte count, writable only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                     total_q <= '0;
        else if (wr_total && !ctrl_en)  total_q <= {bus_wdata[DATA_W-1:2], 2'b00};
    end

    // Delivered and accepted byte counters.
    always_ff @(posedge clk) begin
        if (!rst_n || en_rise) begin
            cur_q <= '0;
            acc_q <= '0;
        end else begin
            if (word_done) cur_q <= cur_q + STEP;
            if (data_push) acc_q <= acc_q + STEP;
        end
    end

    // Sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n || en_rise) begin
            ovf_q  <= 1'b0;
            derr_q <= 1'b0;
        end else begin
            if (data_drop)              ovf_q  <= 1'b1;
            if (ctrl_en && cfg_err_in)  derr_q <= 1'b1;
        end
    end

    // Interrupt: set on done or error while enabled, cleared by disabling.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        irq_q <= 1'b0;
        else if (wr_ctrl && !bus_wdata[CTRL_EN])           irq_q <= 1'b0;
        else if (ctrl_en && (done || ovf_q || derr_q))     irq_q <= 1'b1;
    end

    // Read mux.
    always_comb begin
        stat          = '0;
        stat[ST_OVF]  = ovf_q;
        stat[ST_DERR] = derr_q;
        stat[ST_DONE] = done;
        case (bus_addr)
            A_CTRL:  bus_rdata = {29'b0, ctrl_q};
            A_STAT:  bus_rdata = stat;
            A_FSIZE: bus_rdata = SIZE_BYTES;
            A_FUSED: bus_rdata = DATA_W'(used_words) << 2;
            A_TOTAL: bus_rdata = total_q;
            A_CUR:   bus_rdata = cur_q;
            default: bus_rdata = '0;
        endcase
    end

    // R9: the interrupt is only ever pending while enabled.
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ctrl_en);
    // R5: delivered bytes never pass the total while enabled.
    a_r5_cur_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_en |-> (cur_q <= total_q));
    // R3: overflow stays set until an enabling write.
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !en_rise) |=> ovf_q);
    // R6: total does not move while enabled.
    a_r6_total_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && $past(ctrl_en)) |-> $stable(total_q));
endmodule

// File: rtl/bitstream_loader.sv
// Top of the bitstream loader: register file, word FIFO and byte serialiser.
// Assumes one bus master at a time (CPU or DMA) writing the data window.
module bitstream_loader
    import bsl_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [13:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              dma_req,
    output logic              irq,
    output logic [7:0]        cfg_data,
    output logic              cfg_valid,
    input  logic              cfg_ready,
    input  logic              cfg_done_in,
    input  logic              cfg_err_in,
    output logic              cfg_reset
);
    localparam int FCW = $clog2(DEPTH + 1);
    localparam int CW  = $clog2(DEPTH + 2);

    logic              fifo_full, fifo_empty, fifo_pop, data_push;
    logic [FCW-1:0]    fifo_count;
    logic [DATA_W-1:0] fifo_rdata;
    logic              ctrl_en, allow, word_done, ser_busy;
    logic [CW-1:0]     used_words;

    assign used_words = CW'(fifo_count) + CW'(ser_busy);

    bsl_regs #(.DEPTH(DEPTH)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .fifo_full(fifo_full), .fifo_count(fifo_count), .used_words(used_words),
        .word_done(word_done), .cfg_done_in(cfg_done_in), .cfg_err_in(cfg_err_in),
        .data_push(data_push), .ctrl_en(ctrl_en), .allow(allow),
        .dma_req(dma_req), .irq(irq), .cfg_reset(cfg_reset)
    );

    bsl_fifo #(.W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(!ctrl_en),
        .push(data_push), .wdata(bus_wdata),
        .pop(fifo_pop), .rdata(fifo_rdata),
        .full(fifo_full), .empty(fifo_empty), .count(fifo_count)
    );

    bsl_serializer #(.W(DATA_W), .BYTE_W(BYTE_W)) ser_i (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_en), .allow(allow),
        .src_empty(fifo_empty), .src_data(fifo_rdata), .src_pop(fifo_pop),
        .out_data(cfg_data), .out_valid(cfg_valid), .out_ready(cfg_ready),
        .word_done(word_done), .busy(ser_busy)
    );

    // R11: device reset is never driven while disabled.
    a_r11_reset_gated: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_reset |-> ctrl_en);
    // R3: nothing is offered downstream while disabled.
    a_r3_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && $past(!ctrl_en)) |-> !cfg_valid);
endmodule

// File: tb/bitstream_loader_tb_top.sv
// Directed bench for the bitstream loader.
module bitstream_loader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dma_req, irq, cfg_valid, cfg_reset;
    logic [7:0]  cfg_data;
    logic        cfg_ready = 1'b1;
    logic        cfg_done_in = 1'b0;
    logic        cfg_err_in = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] cap [64];
    int ncap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitstream_loader dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req),
        .irq(irq), .cfg_data(cfg_data), .cfg_valid(cfg_valid),
        .cfg_ready(cfg_ready), .cfg_done_in(cfg_done_in),
        .cfg_err_in(cfg_err_in), .cfg_reset(cfg_reset)
    );

    // Byte capture, sampled mid-cycle after any input change.
    always @(negedge clk) begin
        #2;
        if (cfg_valid && cfg_ready && ncap < 64) begin
            cap[ncap] = cfg_data;
            ncap++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(14'h040, v); check(v == 0, "R1 ctrl", v, 0);
        rd(14'h044, v); check(v == 0, "R1 status", v, 0);
        rd(14'h048, v); check(v == DEPTH*4, "R1 fifo size", v, DEPTH*4);
        rd(14'h04C, v); check(v == 0, "R1 fifo used", v, 0);
        rd(14'h050, v); check(v == 0, "R1 total", v, 0);
        rd(14'h054, v); check(v == 0, "R1 cur", v, 0);
        check({irq, dma_req, cfg_valid, cfg_reset} == 0, "R1 outputs",
              {28'b0, irq, dma_req, cfg_valid, cfg_reset}, 0);
    endtask

    task automatic t_ctrl_total;
        logic [31:0] v;
        wr(14'h040, 32'h6);
        rd(14'h040, v); check(v == 32'h6, "R2 ctrl readback", v, 32'h6);
        wr(14'h040, 32'h0);
        wr(14'h050, 32'd13);
        rd(14'h050, v); check(v == 32'd12, "R6 total low bits", v, 12);
        wr(14'h040, 32'h1);
        wr(14'h050, 32'd99);
        rd(14'h050, v); check(v == 32'd12, "R6 total ignored while enabled", v, 12);
        wr(14'h040, 32'h0);
    endtask

    task automatic t_cpu_load;
        logic [31:0] v;
        logic [31:0] w [3];
        int bad;
        w[0] = 32'hA1B2C3D4; w[1] = 32'h11223344; w[2] = 32'hDEADBEEF;
        wr(14'h040, 32'h0);
        wr(14'h050, 32'd12);
        cfg_ready = 1'b1; cfg_done_in = 1'b0;
        wr(14'h040, 32'h1);
        ncap = 0;
        for (int i = 0; i < 3; i++) wr(14'h3000, w[i]);
        idle(40);
        check(ncap == 12, "R4 byte count", ncap, 12);
        bad = 0;
        for (int i = 0; i < 12; i++)
            if (cap[i] != w[i/4][31 - 8*(i%4) -: 8]) bad++;
        check(bad == 0, "R4 byte order msb first", bad, 0);
        rd(14'h054, v); check(v == 12, "R5 cur after load", v, 12);
        rd(14'h04C, v); check(v == 0, "R7 used drained", v, 0);
        rd(14'h044, v); check(v[18] == 1'b0, "R8 no done without device done", v, 0);
        check(irq == 1'b0, "R9 no irq before done", irq, 0);
        cfg_done_in = 1'b1;
        idle(2);
        rd(14'h044, v); check(v == 32'h0004_0000, "R8 done flag", v, 32'h0004_0000);
        check(irq == 1'b1, "R9 irq on done", irq, 1);
        wr(14'h040, 32'h1);
        check(irq == 1'b1, "R9 irq held by enable rewrite", irq, 1);
        wr(14'h040, 32'h0);
        check(irq == 1'b0, "R9 irq cleared by disable", irq, 0);
        cfg_done_in = 1'b0;
    endtask

    task automatic t_limit;
        logic [31:0] v;
        wr(14'h050, 32'd8);
        cfg_ready = 1'b1;
        wr(14'h040, 32'h1);
        ncap = 0;
        for (int i = 0; i < 3; i++) wr(14'h3000, 32'h01020304 + i);
        idle(30);
        check(ncap == 8, "R4 stop at total", ncap, 8);
        rd(14'h04C, v); check(v == 4, "R7 leftover word counted", v, 4);
        rd(14'h054, v); check(v == 8, "R5 cur equals total", v, 8);
        wr(14'h040, 32'h0);
        idle(2);
        rd(14'h04C, v); check(v == 0, "R3 flush on disable", v, 0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        wr(14'h050, 32'd200);
        cfg_ready = 1'b0;
        wr(14'h3000, 32'h55);
        rd(14'h04C, v); check(v == 0, "R3 write while disabled dropped", v, 0);
        wr(14'h040, 32'h1);
        for (int i = 0; i < DEPTH + 1; i++) wr(14'h3000, i);
        rd(14'h044, v); check(v[2:1] == 2'b00, "R3 no overflow at exactly full", v, 0);
        wr(14'h3000, 32'hFFFF);
        rd(14'h04C, v); check(v == (DEPTH+1)*4, "R7 used at full", v, (DEPTH+1)*4);
        rd(14'h044, v); check(v == 32'h2, "R3 overflow flag", v, 32'h2);
        idle(1);
        check(irq == 1'b1, "R9 irq on error", irq, 1);
        wr(14'h040, 32'h0);
        idle(2);
        check(irq == 1'b0, "R9 irq cleared", irq, 0);
        rd(14'h044, v); check(v == 32'h2, "R3 overflow sticky while off", v, 32'h2);
        wr(14'h040, 32'h1);
        rd(14'h044, v); check(v == 0, "R5 enable clears errors", v, 0);
        rd(14'h054, v); check(v == 0, "R5 enable clears cur", v, 0);
        wr(14'h040, 32'h0);
        cfg_ready = 1'b1;
    endtask

    task automatic t_derr;
        logic [31:0] v;
        wr(14'h050, 32'd40);
        wr(14'h040, 32'h1);
        @(negedge clk); cfg_err_in = 1'b1;
        @(negedge clk); cfg_err_in = 1'b0;
        idle(2);
        rd(14'h044, v); check(v == 32'h4, "R8 downstream error", v, 32'h4);
        check(irq == 1'b1, "R9 irq on downstream error", irq, 1);
        wr(14'h040, 32'h0);
    endtask

    task automatic t_dma;
        logic [31:0] v;
        cfg_ready = 1'b0;
        wr(14'h050, 32'd64);
        check(dma_req == 1'b0, "R10 no request while off", dma_req, 0);
        wr(14'h040, 32'h5);
        check(dma_req == 1'b1, "R10 request with space", dma_req, 1);
        for (int i = 0; i < 9; i++) wr(14'h3000, i);
        check(dma_req == 1'b1, "R10 request at half free", dma_req, 1);
        wr(14'h3000, 32'h9);
        check(dma_req == 1'b0, "R10 drop below half free", dma_req, 0);
        wr(14'h040, 32'h0);
        wr(14'h050, 32'd8);
        wr(14'h040, 32'h5);
        wr(14'h3000, 1); wr(14'h3000, 2);
        check(dma_req == 1'b0, "R10 stop at total accepted", dma_req, 0);
        rd(14'h040, v); check(v == 32'h5, "R2 dma mode readback", v, 5);
        wr(14'h040, 32'h0);
        cfg_ready = 1'b1;
    endtask

    task automatic t_devreset;
        wr(14'h040, 32'h2);
        check(cfg_reset == 1'b0, "R11 reset bit alone", cfg_reset, 0);
        wr(14'h040, 32'h3);
        check(cfg_reset == 1'b1, "R11 reset pulse high", cfg_reset, 1);
        idle(3);
        check(cfg_reset == 1'b1, "R11 reset held", cfg_reset, 1);
        wr(14'h040, 32'h0);
        check(cfg_reset == 1'b0, "R11 reset released", cfg_reset, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_total();
        t_cpu_load();
        t_limit();
        t_overflow();
        t_derr();
        t_dma();
        t_devreset();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule